// File: doc/BRIEF.md
# Interrupt Pin Trigger and Remote-IRR Servicing

This block watches a set of interrupt request lines, one per pin, and decides in which cycle each pin is serviced. Each pin has its own configuration: a polarity bit that inverts the line, a trigger-mode bit that selects edge or level behaviour, a mask bit, and an interrupt vector. The block keeps a pending bit for every pin. For level-triggered pins it also keeps an in-service bit. That bit is set when a delivery is accepted. It holds the pin off until an end-of-interrupt carrying the same vector is seen.

When a pin needs service, the block raises a delivery request that carries the pin index, its vector and its trigger mode. Downstream logic answers in the same cycle with an accept bit. Downstream logic also resolves where the interrupt goes; this block does not. When several pins need service at once, they are taken one per cycle, lowest index first. An end-of-interrupt strobe starts a scan that visits one pin per cycle. The scan clears the in-service bit of every pin whose vector matches. While the scan runs, a busy output is high.

Top module: `irq_pin_service`

## Requirements
- R1: After reset, every pending bit and every in-service bit is 0, `dlv_valid_o` is 0 and `eoi_busy_o` is 0.
- R2: A pin's effective level is `irq_i ^ pol_i`. A low effective level clears the pin's pending bit at the next clock edge, whatever the trigger mode. A level-triggered pin (`lvl_i`=1) sets its pending bit at the next edge while its effective level is high.
- R3: An edge-triggered pin (`lvl_i`=0) sets its pending bit only on a 0-to-1 change of its effective level. It is serviced in the cycle after that change. Its pending bit is 0 again after one more edge. A line held active does not cause a second request.
- R4: A masked edge-triggered pin still takes its service cycle and loses its pending bit. It raises no delivery request.
- R5: A level-triggered pin with its pending bit set, its in-service bit clear and its mask clear raises a request every cycle. When a request is accepted, the pin's in-service bit is set at that edge and the requests stop. A request that is not accepted is repeated in the next cycle.
- R6: Among the pins that need service, exactly one is serviced per cycle, and it is the one with the lowest index. A request always names a pin whose pending bit is set.
- R7: An end-of-interrupt clears the in-service bit of every pin whose vector equals `eoi_vec_i`, including several pins that share that vector. Pins with other vectors keep their in-service bit. A cleared pin that is still pending and unmasked is requested again.
- R8: An accepted end-of-interrupt holds `eoi_busy_o` high for exactly NUM_PINS cycles. A strobe that arrives while busy is ignored.
- R9: Suppose an accepted delivery for a pin and the scan's clear of that same pin fall on the same edge. The in-service bit is then 1 after that edge.
- R10: A masked level-triggered pin keeps its pending bit and raises no request. Once it is unmasked, it raises a request while still pending.
- R11: `dlv_vec_o` and `dlv_lvl_o` carry the vector and trigger mode of the pin named by `dlv_pin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_PINS | Raw interrupt line per pin |
| pol_i | input | NUM_PINS | Polarity per pin, 1 inverts the line |
| lvl_i | input | NUM_PINS | Trigger mode per pin, 1 = level, 0 = edge |
| mask_i | input | NUM_PINS | Mask per pin, 1 = masked |
| vec_i | input | NUM_PINS*VEC_W | Vector per pin, pin i at bits [i*VEC_W +: VEC_W] |
| dlv_valid_o | output | 1 | Delivery request this cycle |
| dlv_pin_o | output | PIN_W | Index of the requesting pin |
| dlv_vec_o | output | VEC_W | Vector of the requesting pin |
| dlv_lvl_o | output | 1 | Trigger mode of the requesting pin |
| dlv_accept_i | input | 1 | Same-cycle accept of the request |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vec_i | input | VEC_W | Vector carried by the end-of-interrupt |
| eoi_busy_o | output | 1 | End-of-interrupt scan in progress |
| pend_o | output | NUM_PINS | Pending bit per pin |
| rirr_o | output | NUM_PINS | In-service bit per pin |

## Verification
The assertions assume the following about the inputs:
- Polarity and trigger mode only change while the pin's effective level stays low.
- `dlv_accept_i` matters only in a cycle where `dlv_valid_o` is high.
- The configuration inputs are steady at the edge where a pin is serviced.

The stimulus keeps within these limits. It changes a pin's polarity and its line together, and it changes a trigger mode only while that line is inactive. It drives every input on the falling clock edge. The same-edge case of R9 is set up on purpose: the accept is raised exactly in the cycle when the scan reaches the pin.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  typedef enum logic {
    EOI_IDLE = 1'b0,
    EOI_SCAN = 1'b1
  } eoi_state_e;

endpackage

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl
  import irq_svc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eff_i,
  input  logic lvl_i,
  input  logic mask_i,
  input  logic svc_i,
  input  logic acc_i,
  input  logic eoi_clr_i,
  output logic need_o,
  output logic pend_o,
  output logic rirr_o
);

  logic eff_q, pend_q, rirr_q;
  trig_e trig;

  assign trig = trig_e'(lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      eff_q <= eff_i;
      if (!eff_i)                pend_q <= 1'b0;
      else if (trig == TRIG_LEVEL) pend_q <= 1'b1;
      else if (!eff_q)           pend_q <= 1'b1;
      else if (svc_i)            pend_q <= 1'b0;
    end
  end

  // set by an accepted level delivery wins over a same-edge scan clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             rirr_q <= 1'b0;
    else if (acc_i && trig == TRIG_LEVEL)    rirr_q <= 1'b1;
    else if (eoi_clr_i)                      rirr_q <= 1'b0;
  end

  // masked edge pins still claim a slot so the edge is consumed
  always_comb begin
    if (trig == TRIG_LEVEL) need_o = pend_q && !rirr_q && !mask_i;
    else                    need_o = pend_q;
  end

  assign pend_o = pend_q;
  assign rirr_o = rirr_q;

  // R2
  inactive_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eff_i |=> !pend_q);

  // R3
  edge_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !lvl_i) |=> !pend_q);

  // R5
  accept_sets_rirr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && lvl_i) |=> rirr_q);

  // R7
  rirr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rirr_q && !eoi_clr_i) |=> rirr_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_PINS = 8,
  parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] req_i,
  output logic [NUM_PINS-1:0] gnt_o,
  output logic [PIN_W-1:0]    idx_o,
  output logic                any_o
);

  logic [NUM_PINS-1:0] seen;

  assign seen[0]  = 1'b0;
  assign gnt_o[0] = req_i[0];

  for (genvar g = 1; g < NUM_PINS; g++) begin : g_chain
    assign seen[g]  = seen[g-1] | req_i[g-1];
    assign gnt_o[g] = req_i[g] & ~seen[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = PIN_W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/irq_eoi_scan.sv
module irq_eoi_scan
  import irq_svc_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vec_i,
  input  logic [NUM_PINS*VEC_W-1:0] vec_i,
  output logic                      busy_o,
  output logic [NUM_PINS-1:0]       clr_o
);

  localparam logic [PIN_W-1:0] LAST_IDX = PIN_W'(NUM_PINS - 1);

  eoi_state_e       state_q;
  logic [PIN_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EOI_IDLE;
      idx_q   <= '0;
      vec_q   <= '0;
    end else begin
      case (state_q)
        EOI_IDLE: begin
          if (eoi_valid_i) begin
            state_q <= EOI_SCAN;
            idx_q   <= '0;
            vec_q   <= eoi_vec_i;
          end
        end
        default: begin
          if (idx_q == LAST_IDX) state_q <= EOI_IDLE;
          else                   idx_q   <= idx_q + PIN_W'(1);
        end
      endcase
    end
  end

  assign busy_o = (state_q == EOI_SCAN);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_match
    assign clr_o[g] = busy_o && (idx_q == PIN_W'(g)) &&
                      (vec_i[g*VEC_W +: VEC_W] == vec_q);
  end

  // R8
  scan_vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(vec_q));

  // R8
  scan_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && idx_q == LAST_IDX) |=> !busy_o);

  // R7
  one_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));

endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
  import irq_svc_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       irq_i,
  input  logic [NUM_PINS-1:0]       pol_i,
  input  logic [NUM_PINS-1:0]       lvl_i,
  input  logic [NUM_PINS-1:0]       mask_i,
  input  logic [NUM_PINS*VEC_W-1:0] vec_i,
  output logic                      dlv_valid_o,
  output logic [PIN_W-1:0]          dlv_pin_o,
  output logic [VEC_W-1:0]          dlv_vec_o,
  output logic                      dlv_lvl_o,
  input  logic                      dlv_accept_i,
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vec_i,
  output logic                      eoi_busy_o,
  output logic [NUM_PINS-1:0]       pend_o,
  output logic [NUM_PINS-1:0]       rirr_o
);

  logic [NUM_PINS-1:0] eff, need, gnt, acc, eoi_clr;
  logic [PIN_W-1:0]    sel;
  logic                any_svc;

  assign eff = irq_i ^ pol_i;

  irq_prio_pick #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_pick (
    .req_i (need),
    .gnt_o (gnt),
    .idx_o (sel),
    .any_o (any_svc)
  );

  irq_eoi_scan #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .PIN_W(PIN_W)) u_eoi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eoi_valid_i (eoi_valid_i),
    .eoi_vec_i   (eoi_vec_i),
    .vec_i       (vec_i),
    .busy_o      (eoi_busy_o),
    .clr_o       (eoi_clr)
  );

  assign dlv_valid_o = any_svc && !mask_i[sel];
  assign dlv_pin_o   = sel;
  assign dlv_vec_o   = vec_i[int'(sel)*VEC_W +: VEC_W];
  assign dlv_lvl_o   = lvl_i[sel];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign acc[g] = gnt[g] && dlv_valid_o && dlv_accept_i;

    irq_pin_ctl u_pin (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .eff_i     (eff[g]),
      .lvl_i     (lvl_i[g]),
      .mask_i    (mask_i[g]),
      .svc_i     (gnt[g]),
      .acc_i     (acc[g]),
      .eoi_clr_i (eoi_clr[g]),
      .need_o    (need[g]),
      .pend_o    (pend_o[g]),
      .rirr_o    (rirr_o[g])
    );
  end

  // R6
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  // R6
  req_from_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> pend_o[dlv_pin_o]);

endmodule

// File: tb/sim_irq_pin_service.sv
module sim_irq_pin_service;

  localparam int N  = 4;
  localparam int VW = 8;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq, pol, lvl, mask;
  logic [N*VW-1:0] vec;
  logic          accept, eoi_valid;
  logic [VW-1:0] eoi_vec;
  logic          dlv_valid, dlv_lvl, eoi_busy;
  logic [PW-1:0] dlv_pin;
  logic [VW-1:0] dlv_vec;
  logic [N-1:0]  pend, rirr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_pin_service #(.NUM_PINS(N), .VEC_W(VW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .pol_i(pol), .lvl_i(lvl),
    .mask_i(mask), .vec_i(vec), .dlv_valid_o(dlv_valid), .dlv_pin_o(dlv_pin),
    .dlv_vec_o(dlv_vec), .dlv_lvl_o(dlv_lvl), .dlv_accept_i(accept),
    .eoi_valid_i(eoi_valid), .eoi_vec_i(eoi_vec), .eoi_busy_o(eoi_busy),
    .pend_o(pend), .rirr_o(rirr)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] vec_of(input int p);
    return VW'(8'h20 + p * 3);
  endfunction

  task automatic run_eoi(input logic [VW-1:0] v);
    eoi_valid = 1'b1;
    eoi_vec   = v;
    tick();
    eoi_valid = 1'b0;
    repeat (N) tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq = '0; pol = '0; lvl = '0; mask = '0;
    accept = 1'b0; eoi_valid = 1'b0; eoi_vec = '0;
    for (int p = 0; p < N; p++) vec[p*VW +: VW] = vec_of(p);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    chk("R1 pend", 32'(pend), 0);
    chk("R1 rirr", 32'(rirr), 0);
    chk("R1 valid", 32'(dlv_valid), 0);
    chk("R1 busy", 32'(eoi_busy), 0);

    // edge pins, both polarities, unmasked then masked
    accept = 1'b1;
    for (int p = 0; p < N; p++) begin
      for (int pv = 0; pv < 2; pv++) begin
        irq[p] = pv[0]; pol[p] = pv[0];
        tick(); tick();
        irq[p] = ~pv[0];
        tick();
        chk("R2 edge pend set", 32'(pend[p]), 1);
        chk("R3 edge request", 32'(dlv_valid), 1);
        chk("R6 pin", 32'(dlv_pin), 32'(p));
        chk("R11 vector", 32'(dlv_vec), 32'(vec_of(p)));
        chk("R11 trig", 32'(dlv_lvl), 0);
        tick();
        chk("R3 pend cleared", 32'(pend[p]), 0);
        chk("R3 no repeat", 32'(dlv_valid), 0);
        tick();
        chk("R3 held line", 32'(dlv_valid), 0);
        irq[p] = pv[0]; mask[p] = 1'b1;
        tick();
        irq[p] = ~pv[0];
        tick();
        chk("R4 masked pend", 32'(pend[p]), 1);
        chk("R4 masked no request", 32'(dlv_valid), 0);
        tick();
        chk("R4 masked consumed", 32'(pend[p]), 0);
        irq[p] = pv[0]; mask[p] = 1'b0;
        tick();
      end
    end

    // level pins: mask hold, unmask, retry, accept, drop, end-of-interrupt
    for (int p = 0; p < N; p++) begin
      for (int pv = 0; pv < 2; pv++) begin
        lvl[p] = 1'b1; mask[p] = 1'b1; accept = 1'b0;
        irq[p] = pv[0]; pol[p] = pv[0];
        tick();
        irq[p] = ~pv[0];
        tick();
        chk("R2 level pend", 32'(pend[p]), 1);
        chk("R10 masked held", 32'(dlv_valid), 0);
        mask[p] = 1'b0;
        tick();
        chk("R10 unmask request", 32'(dlv_valid), 1);
        chk("R6 level pin", 32'(dlv_pin), 32'(p));
        chk("R11 level trig", 32'(dlv_lvl), 1);
        chk("R5 rirr idle", 32'(rirr[p]), 0);
        tick();
        chk("R5 retry", 32'(dlv_valid), 1);
        accept = 1'b1;
        tick();
        chk("R5 rirr set", 32'(rirr[p]), 1);
        chk("R5 held off", 32'(dlv_valid), 0);
        irq[p] = pv[0];
        tick();
        chk("R2 level drop", 32'(pend[p]), 0);
        eoi_valid = 1'b1; eoi_vec = vec_of(p);
        tick();
        eoi_valid = 1'b0;
        chk("R8 busy start", 32'(eoi_busy), 1);
        repeat (N - 1) tick();
        chk("R8 busy span", 32'(eoi_busy), 1);
        tick();
        chk("R8 busy end", 32'(eoi_busy), 0);
        chk("R7 rirr cleared", 32'(rirr[p]), 0);
        lvl[p] = 1'b0;
      end
    end
    irq = '0; pol = '0;
    tick();

    // exhaustive priority over all subsets of edge pins
    accept = 1'b1;
    for (int s = 1; s < (1 << N); s++) begin
      irq = N'(s);
      tick();
      for (int p = 0; p < N; p++) begin
        if (s[p]) begin
          chk("R6 order valid", 32'(dlv_valid), 1);
          chk("R6 order pin", 32'(dlv_pin), 32'(p));
          tick();
        end
      end
      chk("R6 drained", 32'(dlv_valid), 0);
      irq = '0;
      tick();
    end

    // matching vs non-matching end-of-interrupt, re-service
    lvl = 4'b0110; accept = 1'b1;
    irq = 4'b0110;
    tick(); tick(); tick();
    chk("R5 two rirr", 32'(rirr), 32'h6);
    begin
      int hits1, hits2;
      hits1 = 0; hits2 = 0;
      eoi_valid = 1'b1; eoi_vec = vec_of(1);
      tick();
      eoi_valid = 1'b0;
      for (int c = 0; c < N + 1; c++) begin
        if (dlv_valid && dlv_pin == 2'd1) hits1++;
        if (dlv_valid && dlv_pin == 2'd2) hits2++;
        tick();
      end
      chk("R7 reservice count", 32'(hits1), 1);
      chk("R7 other untouched", 32'(hits2), 0);
      chk("R7 rirr after", 32'(rirr), 32'h6);
    end
    irq = '0;
    tick();
    // strobe during scan is ignored
    eoi_valid = 1'b1; eoi_vec = vec_of(1);
    tick();
    eoi_vec = vec_of(2);
    tick();
    eoi_valid = 1'b0;
    repeat (N - 1) tick();
    chk("R8 ignored strobe", 32'(rirr), 32'h4);
    run_eoi(vec_of(2));
    chk("R7 pin2 cleared", 32'(rirr), 0);
    lvl = '0;

    // shared vector
    vec[3*VW +: VW] = vec_of(0);
    lvl = 4'b1001; irq = 4'b1001;
    tick(); tick(); tick();
    chk("R5 shared set", 32'(rirr), 32'h9);
    irq = '0;
    tick();
    run_eoi(vec_of(0));
    chk("R7 shared cleared", 32'(rirr), 0);
    vec[3*VW +: VW] = vec_of(3);
    lvl = '0;
    tick();

    // set and clear on the same edge
    lvl = 4'b0001; accept = 1'b0; irq = 4'b0001;
    tick();
    chk("R5 pending request", 32'(dlv_valid), 1);
    eoi_valid = 1'b1; eoi_vec = vec_of(0);
    tick();
    eoi_valid = 1'b0; accept = 1'b1;
    tick();
    chk("R9 set wins", 32'(rirr[0]), 1);
    repeat (N) tick();
    chk("R9 after scan", 32'(rirr[0]), 1);
    irq = '0;
    tick();
    run_eoi(vec_of(0));
    chk("R7 final clear", 32'(rirr), 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule